// File: doc/BRIEF.md
# Temperature Event Output Controller

This block watches a stream of signed temperature samples and decides when an active-low, open-drain event pin should be pulled down. Each sample is compared against three programmable limits: a high limit and a low limit, which together form a window, and a critical limit. One programmable hysteresis value sets how far a reading must move back before a condition counts as gone. The block produces a single "pull the pin low" request. Outside logic turns that request into the open-drain driver, which either sinks the line or leaves it floating.

A mode field picks how the window result reaches the pin.
- **Interrupt mode** latches a fresh window crossing until software writes a one to the clear-event bit.
- **Comparator mode** follows the window condition, with hysteresis applied on the way back in.
- **Critical-only mode** ignores the window completely.

The critical limit behaves as a comparator in every mode, and a clear-event write does not release it. Software configures the block through a simple write-only port. Samples arrive with a one-cycle valid strobe.

Top module: `tev_event_ctrl`

## Requirements
- R1: After reset the pin request is low (released). The limits reset to high = +4095, low = -4096 and critical = +4095, hysteresis resets to 0 and the mode resets to interrupt, so no sample value can raise an event until software programs the limits.
- R2: The pin request is registered. A sample or a write is reflected in the cycle after its strobe, and the request never changes in a cycle with neither a sample nor a write.
- R3: The window condition becomes active when a sample is above the high limit or below the low limit. It becomes inactive only when a sample is at most high-minus-hysteresis and at least low-plus-hysteresis; otherwise it holds. In comparator mode the request follows the window condition.
- R4: In interrupt mode a sample that turns the window condition from inactive to active sets a latch, and the request follows that latch. Writing a value with bit 0 set to the status address (5) clears the latch. If a crossing and a clear fall in the same cycle, the crossing wins. The latch is updated in every mode.
- R5: A status write with bit 0 clear has no effect on the latch or on the request.
- R6: After a clear, no new interrupt arises while the window condition stays active. A new interrupt needs the window to become inactive and then active again.
- R7: The critical condition becomes active when a sample is above the critical limit. It becomes inactive only when a sample is below critical-minus-hysteresis. It raises the request in every mode and is not affected by a clear-event write.
- R8: In critical-only mode the request equals the critical condition alone; the window condition is ignored.
- R9: Write map: address 0 bits [1:0] set the mode (0 = interrupt, 1 = comparator, 2 = critical-only, 3 = comparator), address 1 bits [7:0] set the unsigned hysteresis, and addresses 2, 3 and 4 take the high, low and critical limits as 13-bit two's complement values (1/16 degree per step).
- R10: A mode write changes the request in the next cycle according to the new mode, using the conditions already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| smp_vld | input | 1 | Temperature sample strobe |
| smp_temp | input | 13 | Signed sample, 1/16 degree per step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 13 | Register write data |
| evt_pull_low | output | 1 | 1 = sink the event pin, 0 = release it |

## Verification
The bench builds the block with its default 13-bit sample width and 8-bit hysteresis. With these values it can drive the extreme codes +4095 and -4096 against the reset limits, and it can program a hysteresis wide enough to push high-minus-hysteresis below the low limit. Random streams of samples, limit and hysteresis rewrites, mode changes and clear writes are mixed with directed cases. The directed cases target the exact hysteresis edges (equal to the release threshold and one step beyond), a crossing in the same cycle as a clear, and a critical hold that a clear cannot release.

// File: rtl/tev_pkg.sv
package tev_pkg;
    typedef enum logic [1:0] {
        MODE_INTR     = 2'd0,
        MODE_COMP     = 2'd1,
        MODE_CRIT     = 2'd2,
        MODE_COMP_ALT = 2'd3
    } tev_mode_e;

    localparam int            ADDR_W = 3;
    localparam logic [2:0]    A_MODE = 3'd0;
    localparam logic [2:0]    A_HYST = 3'd1;
    localparam logic [2:0]    A_HIGH = 3'd2;
    localparam logic [2:0]    A_LOW  = 3'd3;
    localparam logic [2:0]    A_CRIT = 3'd4;
    localparam logic [2:0]    A_STAT = 3'd5;
endpackage

// File: rtl/tev_regs.sv
module tev_regs
    import tev_pkg::*;
#(
    parameter int TW = 13,
    parameter int HW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [TW-1:0]        wr_data,
    output tev_mode_e            mode_cur,
    output tev_mode_e            mode_nxt,
    output logic [HW-1:0]        hyst,
    output logic signed [TW-1:0] lim_hi,
    output logic signed [TW-1:0] lim_lo,
    output logic signed [TW-1:0] lim_crit,
    output logic                 clr_evt
);
    localparam logic [TW-1:0] T_MAX = {1'b0, {(TW-1){1'b1}}};
    localparam logic [TW-1:0] T_MIN = {1'b1, {(TW-1){1'b0}}};

    typedef struct packed {
        tev_mode_e     mode;
        logic [HW-1:0] hyst;
        logic [TW-1:0] hi;
        logic [TW-1:0] lo;
        logic [TW-1:0] crit;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                A_MODE:  cfg_d.mode = tev_mode_e'(wr_data[1:0]);
                A_HYST:  cfg_d.hyst = wr_data[HW-1:0];
                A_HIGH:  cfg_d.hi   = wr_data;
                A_LOW:   cfg_d.lo   = wr_data;
                A_CRIT:  cfg_d.crit = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mode: MODE_INTR, hyst: '0, hi: T_MAX, lo: T_MIN, crit: T_MAX};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_cur = cfg_q.mode;
    assign mode_nxt = cfg_d.mode;
    assign hyst     = cfg_q.hyst;
    assign lim_hi   = $signed(cfg_q.hi);
    assign lim_lo   = $signed(cfg_q.lo);
    assign lim_crit = $signed(cfg_q.crit);
    assign clr_evt  = wr_en && (wr_addr == A_STAT) && wr_data[0];

    // a write to another address must leave the limits it does not target alone
    p_limits_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr == A_STAT) |=> $stable(cfg_q));
endmodule

// File: rtl/tev_window_det.sv
module tev_window_det #(
    parameter int TW = 13,
    parameter int HW = 8
) (
    input  logic signed [TW-1:0] temp,
    input  logic signed [TW-1:0] lim_hi,
    input  logic signed [TW-1:0] lim_lo,
    input  logic [HW-1:0]        hyst,
    input  logic                 err_q,
    output logic                 err_d
);
    localparam int EW = TW + 2;

    logic signed [EW-1:0] t_x, hi_x, lo_x, h_x;
    logic                 outside, inside_h;

    assign t_x  = EW'(temp);
    assign hi_x = EW'(lim_hi);
    assign lo_x = EW'(lim_lo);
    assign h_x  = $signed({{(EW-HW){1'b0}}, hyst});

    assign outside  = (t_x > hi_x) || (t_x < lo_x);
    assign inside_h = (t_x <= hi_x - h_x) && (t_x >= lo_x + h_x);

    always_comb begin
        if (outside)       err_d = 1'b1;
        else if (inside_h) err_d = 1'b0;
        else               err_d = err_q;
    end
endmodule

// File: rtl/tev_crit_det.sv
module tev_crit_det #(
    parameter int TW = 13,
    parameter int HW = 8
) (
    input  logic signed [TW-1:0] temp,
    input  logic signed [TW-1:0] lim_crit,
    input  logic [HW-1:0]        hyst,
    input  logic                 crit_q,
    output logic                 crit_d
);
    localparam int EW = TW + 2;

    logic signed [EW-1:0] t_x, c_x, h_x;

    assign t_x = EW'(temp);
    assign c_x = EW'(lim_crit);
    assign h_x = $signed({{(EW-HW){1'b0}}, hyst});

    always_comb begin
        if (t_x > c_x)            crit_d = 1'b1;
        else if (t_x < c_x - h_x) crit_d = 1'b0;
        else                      crit_d = crit_q;
    end
endmodule

// File: rtl/tev_event_ctrl.sv
module tev_event_ctrl
    import tev_pkg::*;
#(
    parameter int TW = 13,
    parameter int HW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [TW-1:0]     smp_temp,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TW-1:0]     wr_data,
    output logic              evt_pull_low
);
    typedef struct packed {
        logic win;
        logic crit;
        logic intr;
        logic drive;
    } st_t;

    st_t st_d, st_q;

    tev_mode_e            mode_cur, mode_nxt;
    logic [HW-1:0]        hyst;
    logic signed [TW-1:0] lim_hi, lim_lo, lim_crit;
    logic                 clr_evt;
    logic                 win_nx, crit_nx;
    logic signed [TW-1:0] temp_s;

    assign temp_s = $signed(smp_temp);

    tev_regs #(.TW(TW), .HW(HW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mode_cur (mode_cur),
        .mode_nxt (mode_nxt),
        .hyst     (hyst),
        .lim_hi   (lim_hi),
        .lim_lo   (lim_lo),
        .lim_crit (lim_crit),
        .clr_evt  (clr_evt)
    );

    tev_window_det #(.TW(TW), .HW(HW)) u_win (
        .temp   (temp_s),
        .lim_hi (lim_hi),
        .lim_lo (lim_lo),
        .hyst   (hyst),
        .err_q  (st_q.win),
        .err_d  (win_nx)
    );

    tev_crit_det #(.TW(TW), .HW(HW)) u_crit (
        .temp     (temp_s),
        .lim_crit (lim_crit),
        .hyst     (hyst),
        .crit_q   (st_q.crit),
        .crit_d   (crit_nx)
    );

    always_comb begin
        logic rise;
        st_d = st_q;
        rise = 1'b0;
        if (smp_vld) begin
            st_d.win  = win_nx;
            st_d.crit = crit_nx;
            rise      = win_nx && !st_q.win;
        end
        if (clr_evt) st_d.intr = 1'b0;
        if (rise)    st_d.intr = 1'b1;
        case (mode_nxt)
            MODE_INTR: st_d.drive = st_d.intr | st_d.crit;
            MODE_CRIT: st_d.drive = st_d.crit;
            default:   st_d.drive = st_d.win | st_d.crit;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_pull_low = st_q.drive;

    // critical crossing pulls the pin in every mode
    p_crit_pulls_r7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && (temp_s > lim_crit) |=> evt_pull_low);

    // without a sample or a write the pin holds
    p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld && !wr_en |=> $stable(evt_pull_low));

    // a clear with no critical condition and no sample releases the pin in interrupt mode
    p_clear_releases_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr == A_STAT) && wr_data[0] && !smp_vld
        && (mode_cur == MODE_INTR) && !st_q.crit |=> !evt_pull_low);

    // latched interrupt stays until a write arrives
    p_latch_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur == MODE_INTR) && st_q.intr && !wr_en |=> evt_pull_low);

    // status write with bit 0 low changes nothing
    p_zero_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr == A_STAT) && !wr_data[0] && !smp_vld |=> $stable(evt_pull_low));

    // critical-only mode ignores the window
    p_crit_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur == MODE_CRIT) && !wr_en && !smp_vld && !st_q.crit |=> !evt_pull_low);
endmodule

// File: tb/tev_event_ctrl_bench.sv
`timescale 1ns/1ps
module tev_event_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [12:0] smp_temp = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [12:0] wr_data = '0;
    logic        evt_pull_low;

    int n_chk = 0;
    int n_err = 0;

    // reference model state
    int m_hi = 4095, m_lo = -4096, m_crit = 4095, m_hyst = 0, m_mode = 0;
    bit m_win = 0, m_cr = 0, m_int = 0;

    always #2.5 clk = ~clk;

    tev_event_ctrl u_tev_event_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_vld      (smp_vld),
        .smp_temp     (smp_temp),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .evt_pull_low (evt_pull_low)
    );

    function automatic int from13(int v);
        logic [12:0] b;
        b = v[12:0];
        return int'($signed(b));
    endfunction

    function automatic bit model_evt();
        case (m_mode)
            0:       return m_int | m_cr;
            2:       return m_cr;
            default: return m_win | m_cr;
        endcase
    endfunction

    function automatic void model_sample(int t, bit clr);
        bit w, c, rise;
        w = m_win;
        c = m_cr;
        if (t > m_hi || t < m_lo) w = 1;
        else if (t <= m_hi - m_hyst && t >= m_lo + m_hyst) w = 0;
        if (t > m_crit) c = 1;
        else if (t < m_crit - m_hyst) c = 0;
        rise = w && !m_win;
        m_win = w;
        m_cr = c;
        if (clr) m_int = 0;
        if (rise) m_int = 1;
    endfunction

    task automatic chk(string tag, bit act, bit exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s evt_pull_low act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    task automatic do_wr(logic [2:0] a, int v, string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v[12:0];
        case (a)
            3'd0: m_mode = v & 3;
            3'd1: m_hyst = v & 255;
            3'd2: m_hi = from13(v);
            3'd3: m_lo = from13(v);
            3'd4: m_crit = from13(v);
            3'd5: if (v[0]) m_int = 0;
            default: ;
        endcase
        @(negedge clk);
        wr_en = 1'b0;
        chk(tag, evt_pull_low, model_evt());
    endtask

    task automatic do_smp(int t, string tag);
        @(negedge clk);
        smp_vld = 1'b1; smp_temp = t[12:0];
        model_sample(t, 0);
        @(negedge clk);
        smp_vld = 1'b0;
        chk(tag, evt_pull_low, model_evt());
    endtask

    task automatic do_both(int t, string tag);
        @(negedge clk);
        smp_vld = 1'b1; smp_temp = t[12:0];
        wr_en = 1'b1; wr_addr = 3'd5; wr_data = 13'd1;
        model_sample(t, 1);
        @(negedge clk);
        smp_vld = 1'b0; wr_en = 1'b0;
        chk(tag, evt_pull_low, model_evt());
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag, evt_pull_low, model_evt());
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 reset", evt_pull_low, 1'b0);
        rst_n = 1'b1;
        do_smp(4095, "R1 max code vs reset limits");
        do_smp(-4096, "R1 min code vs reset limits");
        idle(3, "R2 idle");

        // comparator mode with a window
        do_wr(3'd0, 1, "R9 mode comparator");
        do_wr(3'd2, 400, "R9 high limit");
        do_wr(3'd3, 0, "R9 low limit");
        do_wr(3'd1, 16, "R9 hysteresis");
        do_wr(3'd4, 1000, "R9 critical limit");
        do_smp(401, "R3 above high");
        idle(2, "R2 hold after sample");
        do_smp(395, "R3 inside hysteresis band");
        do_smp(384, "R3 release at high-hyst");
        do_smp(-1, "R3 below low");
        do_smp(15, "R3 one below low+hyst");
        do_smp(16, "R3 release at low+hyst");

        // interrupt mode
        do_wr(3'd0, 0, "R10 switch to interrupt");
        do_wr(3'd5, 1, "R4 clear stale latch");
        do_smp(401, "R4 crossing sets latch");
        do_smp(200, "R4 latch held back inside");
        do_wr(3'd5, 0, "R5 zero write ignored");
        do_wr(3'd5, 1, "R4 clear releases");
        do_smp(500, "R4 fresh crossing");
        do_wr(3'd5, 1, "R4 clear");
        do_smp(450, "R6 no reassert while outside");
        do_smp(390, "R6 in band keeps condition");
        do_smp(401, "R6 no new crossing");
        do_smp(300, "R6 back inside");
        do_smp(401, "R6 re-cross reasserts");
        do_wr(3'd5, 1, "R4 clear");
        do_smp(300, "R4 inside again");
        do_both(420, "R4 crossing wins over clear");

        // critical handling
        do_wr(3'd5, 1, "R4 clear");
        do_smp(1001, "R7 above critical");
        do_wr(3'd5, 1, "R7 clear cannot release critical");
        do_smp(990, "R7 critical held in band");
        do_smp(984, "R7 critical held at crit-hyst");
        do_smp(983, "R7 critical released below crit-hyst");

        // critical-only mode
        do_wr(3'd0, 2, "R9 mode critical-only");
        do_smp(-100, "R8 window ignored");
        do_smp(1000, "R8 equal to critical does not assert");
        do_smp(1001, "R8 above critical");
        do_smp(-200, "R8 released below crit-hyst");

        // alternate comparator code and mode switch
        do_wr(3'd0, 3, "R9 mode code 3 acts as comparator");
        do_smp(500, "R9 code 3 follows window");
        do_wr(3'd0, 2, "R10 switch to critical-only drops window");
        do_wr(3'd0, 1, "R10 switch back to comparator");
        idle(2, "R2 idle");

        // random phase
        for (int i = 0; i < 1500; i++) begin
            int r;
            r = int'($urandom_range(15));
            case (r)
                0: do_wr(3'd5, int'($urandom_range(1)), "R4/R5 random clear");
                1: do_wr(3'd0, int'($urandom_range(3)), "R10 random mode");
                2: do_wr(3'd1, int'($urandom_range(80)), "R3/R7 random hyst");
                3: do_wr(3'd2, int'($urandom_range(400)) + 200, "R3 random high");
                4: do_wr(3'd3, int'($urandom_range(300)) - 100, "R3 random low");
                5: do_wr(3'd4, int'($urandom_range(500)) + 700, "R7 random critical");
                6: idle(1, "R2 random idle");
                default: do_smp(int'($urandom_range(1500)) - 200, "R3/R4/R6/R7/R8 random sample");
            endcase
        end
        do_smp(4095, "R7 top code");
        do_smp(-4096, "R3 bottom code");

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule